// File: doc/BRIEF.md
# Write-Only Serial Current-Setting Receiver

This block is a target on a two-wire serial bus (I2C-style signalling) that accepts writes only. It holds the drive setting of a constant-current motor driver: an 8-bit current code and a power-down flag. It samples the bus clock and data lines with a fast system clock. It recognises START and STOP conditions and takes in a fixed frame of three bytes: an address byte with a write direction bit, then two data bytes. The code and the flag are split across the two data bytes.

Each byte the block accepts is acknowledged by pulling the data line low through an open-drain output. The two registered outputs change together, and only once the third byte has been acknowledged. A frame that the host breaks off leaves them as they were. The output code maps linearly onto the drive current: 0 means no current and 255 means full scale. The system clock must run at least 16 times faster than the bus clock, which may go up to 400 kHz.

Top module: `i2c_current_rx`

## Requirements
- R1: SDA falling while SCL is high is a START. It begins a new frame from any state. SDA rising while SCL is high is a STOP. It ends any frame in progress.
- R2: Bits are shifted in on each SCL rising edge, most significant bit first, eight per byte.
- R3: The address byte 0x66 (target address 0110011, direction bit 0) is acknowledged. `sda_pull_o` goes high after the SCL fall that ends bit 8 and goes low again after the following (ninth) SCL fall.
- R4: Any other address byte is not acknowledged, including 0x67 (read). The block then ignores the bus until the next START or STOP: no later byte is acknowledged and the outputs do not change.
- R5: After an accepted address, the second and third bytes are acknowledged. A fourth or later byte in the same frame is not acknowledged and does not change the outputs.
- R6: In the second byte, bit 7 is the power-down flag, bit 6 is ignored and bits 5..0 give code[7:2]. In the third byte, bits 7..6 give code[1:0] and bits 5..0 are ignored.
- R7: `code_o` and `pd_o` update together at the ninth SCL fall of the third byte. The new value appears three system clock cycles after SCL goes low at the pin, and the outputs hold in every other cycle.
- R8: A frame cut short by a STOP or a repeated START, before its third byte is acknowledged, leaves `code_o` and `pd_o` unchanged.
- R9: While `rst_n` is low at a clock edge, `code_o` and `pd_o` are cleared to 0, `sda_pull_o` is released, and any frame in progress is dropped.
- R10: Both end codes pass through: 0x00 and 0xFF reach `code_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low power-down and reset, sampled synchronously |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sda_pull_o | output | 1 | 1 drives the data line low (open-drain acknowledge) |
| code_o | output | 8 | Registered current code, 0 = off, 255 = full scale |
| pd_o | output | 1 | Registered power-down flag |

## Verification
The hardest situations to reach are the frames that must leave the outputs alone even though bytes keep arriving. These are a frame cut by a repeated START after two good bytes, a fourth byte after a complete frame, and data bytes that follow a rejected or read-direction address. The bench drives the bus as an open-drain wire that combines its own data with the block's pull, so acknowledges feed back onto the line the block samples. It scripts those broken frames between complete ones that carry distinct codes. A reference model, updated in the exact clock cycle the requirements give, is compared against both outputs on every clock. Any early, late or spurious update therefore shows as a mismatch in a specific cycle.

// File: rtl/i2c_cur_pkg.sv
package i2c_cur_pkg;
  localparam int CODE_W = 8;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_SKIP} rx_state_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bus_events.sv
module bus_events #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n(rst_n),
      .din (raw[g]),
      .dout(synced[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '1;
    else        prev <= synced;
  end

  logic scl_now, sda_now, scl_old, sda_old;
  assign scl_now = synced[0];
  assign sda_now = synced[1];
  assign scl_old = prev[0];
  assign sda_old = prev[1];

  assign sda_s    = sda_now;
  assign scl_rise = scl_now & ~scl_old;
  assign scl_fall = ~scl_now & scl_old;
  assign start_ev = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_ev  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import i2c_cur_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b0110011,
  parameter int         NBYTES      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              sda_pull,
  output logic              commit,
  output logic              pd_next,
  output logic [CODE_W-1:0] code_next,
  output rx_state_t         state,
  output logic [3:0]        bit_cnt
);
  localparam int IDX_W = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {TARGET_ADDR, 1'b0};
  localparam int HI_W = CODE_W - 2;

  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  byte_idx;
  logic              hold_pd;
  logic [HI_W-1:0]   hold_hi;
  logic              accept;

  assign accept    = (byte_idx == '0) ? (shreg == ADDR_BYTE) : 1'b1;
  assign commit    = (state == RX_ACK) && scl_fall && (byte_idx == LAST_IDX);
  assign pd_next   = hold_pd;
  assign code_next = {hold_hi, shreg[BYTE_W-1 -: 2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      hold_pd  <= 1'b0;
      hold_hi  <= '0;
      sda_pull <= 1'b0;
    end else if (start_ev) begin
      state    <= RX_BITS;
      bit_cnt  <= '0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
    end else if (stop_ev) begin
      state    <= RX_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        RX_BITS: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (accept) begin
              sda_pull <= 1'b1;
              state    <= RX_ACK;
              if (byte_idx == IDX_W'(1)) begin
                hold_pd <= shreg[BYTE_W-1];
                hold_hi <= shreg[HI_W-1:0];
              end
            end else begin
              state <= RX_SKIP;
            end
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
            if (byte_idx == LAST_IDX) begin
              state <= RX_SKIP;
            end else begin
              state    <= RX_BITS;
              byte_idx <= byte_idx + IDX_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_current_rx.sv
module i2c_current_rx
  import i2c_cur_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'b0110011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [CODE_W-1:0] code_o,
  output logic              pd_o
);
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic commit, pd_next;
  logic [CODE_W-1:0] code_next;
  rx_state_t rx_state;
  logic [3:0] bit_cnt;

  bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_i   (sda_i),
    .sda_s   (sda_s),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  frame_rx #(.TARGET_ADDR(TARGET_ADDR), .NBYTES(3)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_pull (sda_pull_o),
    .commit   (commit),
    .pd_next  (pd_next),
    .code_next(code_next),
    .state    (rx_state),
    .bit_cnt  (bit_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o <= '0;
      pd_o   <= 1'b0;
    end else if (commit) begin
      code_o <= code_next;
      pd_o   <= pd_next;
    end
  end
endmodule

// File: rtl/i2c_cur_chk.sv
module i2c_cur_chk
  import i2c_cur_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              start_ev,
  input logic              stop_ev,
  input logic              commit,
  input logic              sda_pull_o,
  input logic [CODE_W-1:0] code_o,
  input logic              pd_o,
  input rx_state_t         rx_state,
  input logic [3:0]        bit_cnt
);
  a_r3_pull_begins_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> $past(scl_fall));

  a_r3_pull_ends_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev) || !$past(rst_n)));

  a_r7_hold_between_commits: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(commit)) |-> ($stable(code_o) && $stable(pd_o)));

  a_r4_quiet_when_skipping: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_state == RX_IDLE || rx_state == RX_SKIP) |-> !sda_pull_o);

  a_r2_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);
endmodule

bind i2c_current_rx i2c_cur_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_fall  (scl_fall),
  .start_ev  (start_ev),
  .stop_ev   (stop_ev),
  .commit    (commit),
  .sda_pull_o(sda_pull_o),
  .code_o    (code_o),
  .pd_o      (pd_o),
  .rx_state  (rx_state),
  .bit_cnt   (bit_cnt)
);

// File: tb/tb_i2c_current_rx.sv
module tb_i2c_current_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [7:0] code;
  logic pd;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_current_rx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .code_o(code), .pd_o(pd)
  );

  int tests = 0, fails = 0;
  int clk_tests = 0, clk_fails = 0;
  bit cmp_en = 0, done = 0;

  // reference model: pending commit applied three clock edges after SCL fall
  int req_id = 0, req_seen = 0, cd = 0;
  logic [7:0] pend_code = 8'h00, exp_code = 8'h00;
  logic       pend_pd = 1'b0, exp_pd = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_code <= 8'h00; exp_pd <= 1'b0; cd <= 0; req_seen <= req_id;
    end else if (req_id != req_seen) begin
      req_seen <= req_id; cd <= 2;
    end else if (cd == 1) begin
      cd <= 0; exp_code <= pend_code; exp_pd <= pend_pd;
    end else if (cd > 1) begin
      cd <= cd - 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      clk_tests++;
      if (code !== exp_code || pd !== exp_pd) begin
        clk_fails++;
        $display("FAIL R7 cycle compare: code=%0h pd=%0b expected code=%0h pd=%0b",
                 code, pd, exp_code, exp_pd);
      end
    end
  end

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b1; wait_q(Q);
  endtask

  task automatic bus_restart();
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q);
    sda_m = 1'b0; wait_q(Q);
    scl_m = 1'b0; wait_q(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input bit commits,
                           input string req);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q(Q);
      scl_m = 1'b1; wait_q(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wait_q(Q);
    scl_m = 1'b1; wait_q(Q/2);
    got = sda_pull;
    wait_q(Q/2);
    scl_m = 1'b0;
    if (commits) req_id++;
    chk(req, int'(got), int'(exp_ack));
    wait_q(Q);
  endtask

  task automatic full_write(input logic [7:0] b1, input logic [7:0] b2, input string req);
    pend_pd   = b1[7];
    pend_code = {b1[5:0], b2[7:6]};
    bus_start();
    send_byte(8'h66, 1'b1, 1'b0, "R3 address ack");
    send_byte(b1, 1'b1, 1'b0, "R5 second byte ack");
    send_byte(b2, 1'b1, 1'b1, "R5 third byte ack");
    bus_stop();
    chk({req, " code"}, int'(code), int'({b1[5:0], b2[7:6]}));
    chk({req, " pd"}, int'(pd), int'(b1[7]));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      $display("FAIL R1 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests + clk_tests + 1, fails + clk_fails + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 reset code", int'(code), 0);
    chk("R9 reset pd", int'(pd), 0);
    chk("R9 reset pull", int'(sda_pull), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    wait_q(Q);

    // R2/R6: plain frame, MSB first
    full_write(8'h29, 8'h40, "R6 basic");
    // R6: ignored bits set to 1 must not leak
    full_write(8'hCF, 8'h3F, "R6 ignored bits");
    // R10: end codes
    full_write(8'h3F, 8'hC0, "R10 full scale");
    full_write(8'h40, 8'h3F, "R10 zero code");
    full_write(8'h29, 8'h40, "R6 restore");

    // R4: wrong address, data after it ignored
    bus_start();
    send_byte(8'h68, 1'b0, 1'b0, "R4 wrong address");
    send_byte(8'h80, 1'b0, 1'b0, "R4 byte after wrong address");
    send_byte(8'h00, 1'b0, 1'b0, "R4 byte after wrong address");
    bus_stop();
    chk("R4 code kept", int'(code), 8'hA5);

    // R4: read direction refused
    bus_start();
    send_byte(8'h67, 1'b0, 1'b0, "R4 read request");
    send_byte(8'h80, 1'b0, 1'b0, "R4 byte after read request");
    send_byte(8'h00, 1'b0, 1'b0, "R4 byte after read request");
    bus_stop();
    chk("R4 pd kept", int'(pd), 0);

    // R8: frame cut by STOP
    bus_start();
    send_byte(8'h66, 1'b1, 1'b0, "R3 address ack");
    send_byte(8'h80, 1'b1, 1'b0, "R5 second byte ack");
    bus_stop();
    chk("R8 stop cut code", int'(code), 8'hA5);
    chk("R8 stop cut pd", int'(pd), 0);

    // R8/R1: repeated START abandons a frame, new frame completes
    bus_start();
    send_byte(8'h66, 1'b1, 1'b0, "R3 address ack");
    send_byte(8'h95, 1'b1, 1'b0, "R5 second byte ack");
    bus_restart();
    chk("R8 restart cut code", int'(code), 8'hA5);
    pend_pd = 1'b0; pend_code = 8'h4A;
    send_byte(8'h66, 1'b1, 1'b0, "R1 address after restart");
    send_byte(8'h12, 1'b1, 1'b0, "R5 second byte ack");
    send_byte(8'h80, 1'b1, 1'b1, "R5 third byte ack");
    bus_stop();
    chk("R1 restart frame code", int'(code), 8'h4A);

    // R5: fourth byte not acknowledged, outputs keep third-byte result
    pend_pd = 1'b0; pend_code = 8'h07;
    bus_start();
    send_byte(8'h66, 1'b1, 1'b0, "R3 address ack");
    send_byte(8'h01, 1'b1, 1'b0, "R5 second byte ack");
    send_byte(8'hC0, 1'b1, 1'b1, "R5 third byte ack");
    send_byte(8'hAA, 1'b0, 1'b0, "R5 fourth byte refused");
    bus_stop();
    chk("R5 fourth byte code", int'(code), 8'h07);

    // R9: reset clears outputs
    full_write(8'hBF, 8'hC0, "R6 pd with full code");
    @(negedge clk); rst_n = 1'b0;
    wait_q(2);
    chk("R9 reset clears code", int'(code), 0);
    chk("R9 reset clears pd", int'(pd), 0);
    chk("R9 reset releases pull", int'(sda_pull), 0);
    rst_n = 1'b1;
    wait_q(Q);
    full_write(8'h80, 8'h00, "R9 frame after reset");

    wait_q(Q);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests + clk_tests, fails + clk_fails);
    $finish;
  end
endmodule